// File: doc/BRIEF.md
# Segment Decode and Hash Unit

This block holds the sixteen segment registers of a segmented address translator and turns each effective address into the context a later page lookup needs. The top four address bits pick one segment register. From it the block reports the protection key for the current privilege level, the no-execute and direct-store flags and the 24-bit virtual segment ID. From the segment ID and the page index it forms the primary and secondary hash, the packed compare tag, the compare word a miss handler would load, and the two hash-group addresses inside a page table whose base and mask are held in a configuration register.

Before any lookup the block classifies the access. With translation off for the access class, it passes the address through with full rights. In a direct-store segment only integer accesses with a matching key and cache-maintenance operations pass; the rest fault. A fetch from a no-execute segment faults with an execute-protection status. Anything else is handed on for a page lookup. Each request is answered exactly one cycle later, and a register or configuration write in the same cycle as a request is already seen by that request.

Top module: `segHashUnit`

## Requirements
- R1: With srWrEn high at a clock edge, srWrData is stored in segment register srWrIdx; a request uses the register numbered by reqAddr[31:28].
- R2: rspKey is 1 when the selected register has bit 29 set and reqUser is 1, or has bit 30 set and reqUser is 0; otherwise it is 0.
- R3: rspDirect reports bit 31 of the selected register, rspNoExec reports bit 28, and rspVsid reports bits 23:0.
- R4: rspHashPri equals the segment ID XOR the page index reqAddr[27:12] (zero-extended to 24 bits); rspHashSec is its bitwise complement.
- R5: rspTag equals (segment ID shifted left by 7) OR (page index shifted right by 10); rspCmpWord is rspTag with bit 31 also set.
- R6: With cfgWrEn high at a clock edge, cfgWrBase and cfgWrMask become the table base and mask; rspGrpPri and rspGrpSec equal base + ((hash AND mask) shifted left by 6), modulo 2^32, for the primary and secondary hash.
- R7: A fetch (reqKind 1) that is translated, in a segment without the direct-store bit but with the no-execute bit, gives rspResult 3 (no-execute fault) and rspStatus 32'h1000_0000.
- R8: A translated access in a direct-store segment with reqKind 4 (cache maintenance) gives rspResult 1 (pass) and rspPhys equal to reqAddr; reqKind 1 (fetch), 2 (floating point), 3 (reservation), 5 (external control), 6 and 7 give rspResult 4 (direct-store fault), with rspStatus 32'h1000_0000 for a fetch and 0 otherwise.
- R9: A translated access in a direct-store segment with reqKind 0 (integer) gives rspResult 2 (protection fault) for a load (reqStore 0) with key 1 or a store (reqStore 1) with key 0, and otherwise rspResult 1 with rspPhys equal to reqAddr.
- R10: When translation is off for the access class (xlateOnInst low for reqKind 1, xlateOnData low for every other kind), the result is rspResult 1, rspPhys equal to reqAddr and rspPerm 3'b111 (read, write, execute), whatever the segment holds.
- R11: Every other request gives rspResult 0 (page lookup needed) with rspPhys 0, rspPerm 0 and rspStatus 0; rspPerm is 0 for every result not covered by R10.
- R12: rspValid is high for exactly the one cycle after each cycle with reqValid high, and every response output holds its value while no request arrives.
- R13: A segment-register write or configuration write in the same cycle as a request is already used by that request; a write to another register leaves the requested segment unchanged.
- R14: After reset all segment registers, the table base and mask and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srWrEn | input | 1 | Segment register write strobe |
| srWrIdx | input | 4 | Segment register number to write |
| srWrData | input | 32 | Segment register write value |
| cfgWrEn | input | 1 | Table configuration write strobe |
| cfgWrBase | input | 32 | Page-table base address |
| cfgWrMask | input | MASK_W | Hash mask for group selection |
| reqValid | input | 1 | Request present |
| reqAddr | input | 32 | Effective address |
| reqKind | input | 3 | Access class: 0 integer, 1 fetch, 2 float, 3 reservation, 4 cache op, 5 external, 6-7 spare |
| reqStore | input | 1 | 1 for a store, 0 for a load |
| reqUser | input | 1 | 1 for user privilege, 0 for supervisor |
| xlateOnInst | input | 1 | Instruction translation enabled |
| xlateOnData | input | 1 | Data translation enabled |
| rspValid | output | 1 | Response present |
| rspResult | output | 3 | 0 lookup, 1 pass, 2 protection fault, 3 no-execute fault, 4 direct-store fault |
| rspKey | output | 1 | Protection key |
| rspNoExec | output | 1 | No-execute flag of the segment |
| rspDirect | output | 1 | Direct-store flag of the segment |
| rspVsid | output | 24 | Virtual segment ID |
| rspHashPri | output | 24 | Primary hash |
| rspHashSec | output | 24 | Secondary hash |
| rspTag | output | 31 | Packed compare tag |
| rspCmpWord | output | 32 | Miss compare word |
| rspGrpPri | output | 32 | Primary hash-group address |
| rspGrpSec | output | 32 | Secondary hash-group address |
| rspPhys | output | 32 | Physical address for passed accesses, else 0 |
| rspPerm | output | 3 | Granted rights {exec, write, read}, full only in real mode |
| rspStatus | output | 32 | Execute-protection status word |

## Verification
The two functions that can meet in one cycle are a register or configuration write and a lookup through that same register or configuration. The bench drives a segment write together with a request whose top address bits select the written register, then a write to a different register together with a request to a neighbour, and a configuration write together with a request. The response is judged against a reference model whose mirror is updated before the expected values are formed, so the new segment fields and group addresses must appear in the very response of the request that shared the cycle, while the neighbour keeps its old fields.

// File: rtl/segHashPkg.sv
package segHashPkg;

  localparam int EA_W       = 32;
  localparam int SEG_SEL_W  = 4;
  localparam int SR_COUNT   = 1 << SEG_SEL_W;
  localparam int VSID_W     = 24;
  localparam int PAGE_LSB   = 12;
  localparam int PGIDX_W    = EA_W - SEG_SEL_W - PAGE_LSB;
  localparam int TAG_SHIFT  = 7;
  localparam int TAG_DROP   = 10;
  localparam int TAG_W      = VSID_W + TAG_SHIFT;
  localparam int PERM_W     = 3;

  // segment register field positions
  localparam int SR_DIRECT_BIT = 31;
  localparam int SR_SUPKEY_BIT = 30;
  localparam int SR_USRKEY_BIT = 29;
  localparam int SR_NOEXEC_BIT = 28;

  localparam logic [EA_W-1:0] EXEC_STATUS = 32'h1000_0000;

  typedef enum logic [2:0] {
    KIND_INT   = 3'd0,
    KIND_CODE  = 3'd1,
    KIND_FLOAT = 3'd2,
    KIND_RSV   = 3'd3,
    KIND_CACHE = 3'd4,
    KIND_EXT   = 3'd5,
    KIND_SP6   = 3'd6,
    KIND_SP7   = 3'd7
  } accessKind_e;

  typedef enum logic [2:0] {
    RES_LOOKUP = 3'd0,
    RES_PASS   = 3'd1,
    RES_PROT   = 3'd2,
    RES_NOEXEC = 3'd3,
    RES_DSBAD  = 3'd4
  } result_e;

  typedef struct packed {
    logic loadRsp;
    logic writeSr;
    logic writeCfg;
    logic passAddr;
    logic fullPerm;
    logic execStatus;
  } ctrlStrobe_t;

endpackage

// File: rtl/segHashCtrl.sv
module segHashCtrl
  import segHashPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqKind,
  input  logic        reqStore,
  input  logic        xlateOnInst,
  input  logic        xlateOnData,
  input  logic        srWrEn,
  input  logic        cfgWrEn,
  input  logic        fieldKey,
  input  logic        fieldDirect,
  input  logic        fieldNoExec,
  output ctrlStrobe_t strobe,
  output logic        rspValid,
  output logic [2:0]  rspResult
);

  accessKind_e kind;
  result_e     nextRes;
  logic        realMode;
  logic        passAddr;
  logic        execStat;

  assign kind = accessKind_e'(reqKind);

  always_comb begin
    nextRes  = RES_LOOKUP;
    passAddr = 1'b0;
    execStat = 1'b0;
    realMode = (kind == KIND_CODE) ? !xlateOnInst : !xlateOnData;
    if (realMode) begin
      nextRes  = RES_PASS;
      passAddr = 1'b1;
    end else if (fieldDirect) begin
      case (kind)
        KIND_INT: begin
          if (reqStore ? !fieldKey : fieldKey) begin
            nextRes = RES_PROT;
          end else begin
            nextRes  = RES_PASS;
            passAddr = 1'b1;
          end
        end
        KIND_CACHE: begin
          nextRes  = RES_PASS;
          passAddr = 1'b1;
        end
        KIND_CODE: begin
          nextRes  = RES_DSBAD;
          execStat = 1'b1;
        end
        default: nextRes = RES_DSBAD;
      endcase
    end else if (kind == KIND_CODE && fieldNoExec) begin
      nextRes  = RES_NOEXEC;
      execStat = 1'b1;
    end
  end

  always_comb begin
    strobe.loadRsp    = reqValid;
    strobe.writeSr    = srWrEn;
    strobe.writeCfg   = cfgWrEn;
    strobe.passAddr   = passAddr;
    strobe.fullPerm   = realMode;
    strobe.execStatus = execStat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspResult <= 3'd0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) rspResult <= nextRes;
    end
  end

endmodule

// File: rtl/segHashPath.sv
module segHashPath
  import segHashPkg::*;
#(
  parameter int GROUP_SHIFT = 6,
  parameter int MASK_W      = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [SEG_SEL_W-1:0]  srWrIdx,
  input  logic [EA_W-1:0]       srWrData,
  input  logic [EA_W-1:0]       cfgWrBase,
  input  logic [MASK_W-1:0]     cfgWrMask,
  input  logic [EA_W-1:0]       reqAddr,
  input  logic                  reqUser,
  output logic                  fieldKey,
  output logic                  fieldDirect,
  output logic                  fieldNoExec,
  output logic                  rspKey,
  output logic                  rspNoExec,
  output logic                  rspDirect,
  output logic [VSID_W-1:0]     rspVsid,
  output logic [VSID_W-1:0]     rspHashPri,
  output logic [VSID_W-1:0]     rspHashSec,
  output logic [TAG_W-1:0]      rspTag,
  output logic [EA_W-1:0]       rspCmpWord,
  output logic [EA_W-1:0]       rspGrpPri,
  output logic [EA_W-1:0]       rspGrpSec,
  output logic [EA_W-1:0]       rspPhys,
  output logic [PERM_W-1:0]     rspPerm,
  output logic [EA_W-1:0]       rspStatus
);

  // ---------------- segment register file ----------------
  logic [SR_COUNT-1:0][EA_W-1:0] srFlat;

  for (genvar g = 0; g < SR_COUNT; g++) begin : gSr
    logic [EA_W-1:0] srReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        srReg <= '0;
      else if (strobe.writeSr && srWrIdx == SEG_SEL_W'(g))
        srReg <= srWrData;
    end
    assign srFlat[g] = srReg;
  end

  // ---------------- table configuration ----------------
  logic [EA_W-1:0]   cfgBase;
  logic [MASK_W-1:0] cfgMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBase <= '0;
      cfgMask <= '0;
    end else if (strobe.writeCfg) begin
      cfgBase <= cfgWrBase;
      cfgMask <= cfgWrMask;
    end
  end

  // ---------------- selection with same-cycle write bypass ----------------
  logic [SEG_SEL_W-1:0] segIdx;
  logic [EA_W-1:0]      srEff;
  logic [EA_W-1:0]      baseEff;
  logic [MASK_W-1:0]    maskEff;
  logic [VSID_W-1:0]    maskExt;

  assign segIdx  = reqAddr[EA_W-1 -: SEG_SEL_W];
  assign srEff   = (strobe.writeSr && srWrIdx == segIdx) ? srWrData : srFlat[segIdx];
  assign baseEff = strobe.writeCfg ? cfgWrBase : cfgBase;
  assign maskEff = strobe.writeCfg ? cfgWrMask : cfgMask;

  always_comb begin
    maskExt = '0;
    maskExt[MASK_W-1:0] = maskEff;
  end

  // ---------------- field decode ----------------
  logic [VSID_W-1:0]  vsid;
  logic [PGIDX_W-1:0] pgIdx;
  logic               unusedSrBits;

  assign vsid         = srEff[VSID_W-1:0];
  assign pgIdx        = reqAddr[PAGE_LSB +: PGIDX_W];
  assign fieldDirect  = srEff[SR_DIRECT_BIT];
  assign fieldNoExec  = srEff[SR_NOEXEC_BIT];
  assign fieldKey     = (srEff[SR_USRKEY_BIT] & reqUser) | (srEff[SR_SUPKEY_BIT] & ~reqUser);
  assign unusedSrBits = ^srEff[SR_NOEXEC_BIT-1:VSID_W];

  // ---------------- hashes, tag and group addresses ----------------
  logic [VSID_W-1:0]          hashPri;
  logic [1:0][VSID_W-1:0]     hashVar;
  logic [1:0][EA_W-1:0]       grpNext;
  logic [TAG_W-1:0]           tagNext;

  assign hashPri = vsid ^ VSID_W'(pgIdx);
  assign tagNext = (TAG_W'(vsid) << TAG_SHIFT) | TAG_W'(pgIdx >> TAG_DROP);

  for (genvar v = 0; v < 2; v++) begin : gHash
    localparam bit INVERT = (v != 0);
    assign hashVar[v] = INVERT ? ~hashPri : hashPri;
    assign grpNext[v] = baseEff + (EA_W'(hashVar[v] & maskExt) << GROUP_SHIFT);
  end

  // ---------------- response registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspKey     <= 1'b0;
      rspNoExec  <= 1'b0;
      rspDirect  <= 1'b0;
      rspVsid    <= '0;
      rspHashPri <= '0;
      rspHashSec <= '0;
      rspTag     <= '0;
      rspCmpWord <= '0;
      rspGrpPri  <= '0;
      rspGrpSec  <= '0;
      rspPhys    <= '0;
      rspPerm    <= '0;
      rspStatus  <= '0;
    end else if (strobe.loadRsp) begin
      rspKey     <= fieldKey;
      rspNoExec  <= fieldNoExec;
      rspDirect  <= fieldDirect;
      rspVsid    <= vsid;
      rspHashPri <= hashVar[0];
      rspHashSec <= hashVar[1];
      rspTag     <= tagNext;
      rspCmpWord <= {1'b1, tagNext};
      rspGrpPri  <= grpNext[0];
      rspGrpSec  <= grpNext[1];
      rspPhys    <= strobe.passAddr ? reqAddr : '0;
      rspPerm    <= strobe.fullPerm ? '1 : '0;
      rspStatus  <= strobe.execStatus ? EXEC_STATUS : '0;
    end
  end

endmodule

// File: rtl/segHashUnit.sv
module segHashUnit
  import segHashPkg::*;
#(
  parameter int GROUP_SHIFT = 6,
  parameter int MASK_W      = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 srWrEn,
  input  logic [SEG_SEL_W-1:0] srWrIdx,
  input  logic [EA_W-1:0]      srWrData,
  input  logic                 cfgWrEn,
  input  logic [EA_W-1:0]      cfgWrBase,
  input  logic [MASK_W-1:0]    cfgWrMask,
  input  logic                 reqValid,
  input  logic [EA_W-1:0]      reqAddr,
  input  logic [2:0]           reqKind,
  input  logic                 reqStore,
  input  logic                 reqUser,
  input  logic                 xlateOnInst,
  input  logic                 xlateOnData,
  output logic                 rspValid,
  output logic [2:0]           rspResult,
  output logic                 rspKey,
  output logic                 rspNoExec,
  output logic                 rspDirect,
  output logic [VSID_W-1:0]    rspVsid,
  output logic [VSID_W-1:0]    rspHashPri,
  output logic [VSID_W-1:0]    rspHashSec,
  output logic [TAG_W-1:0]     rspTag,
  output logic [EA_W-1:0]      rspCmpWord,
  output logic [EA_W-1:0]      rspGrpPri,
  output logic [EA_W-1:0]      rspGrpSec,
  output logic [EA_W-1:0]      rspPhys,
  output logic [PERM_W-1:0]    rspPerm,
  output logic [EA_W-1:0]      rspStatus
);

  ctrlStrobe_t strobe;
  logic        fieldKey;
  logic        fieldDirect;
  logic        fieldNoExec;

  segHashCtrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .reqStore   (reqStore),
    .xlateOnInst(xlateOnInst),
    .xlateOnData(xlateOnData),
    .srWrEn     (srWrEn),
    .cfgWrEn    (cfgWrEn),
    .fieldKey   (fieldKey),
    .fieldDirect(fieldDirect),
    .fieldNoExec(fieldNoExec),
    .strobe     (strobe),
    .rspValid   (rspValid),
    .rspResult  (rspResult)
  );

  segHashPath #(
    .GROUP_SHIFT(GROUP_SHIFT),
    .MASK_W     (MASK_W)
  ) path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srWrIdx    (srWrIdx),
    .srWrData   (srWrData),
    .cfgWrBase  (cfgWrBase),
    .cfgWrMask  (cfgWrMask),
    .reqAddr    (reqAddr),
    .reqUser    (reqUser),
    .fieldKey   (fieldKey),
    .fieldDirect(fieldDirect),
    .fieldNoExec(fieldNoExec),
    .rspKey     (rspKey),
    .rspNoExec  (rspNoExec),
    .rspDirect  (rspDirect),
    .rspVsid    (rspVsid),
    .rspHashPri (rspHashPri),
    .rspHashSec (rspHashSec),
    .rspTag     (rspTag),
    .rspCmpWord (rspCmpWord),
    .rspGrpPri  (rspGrpPri),
    .rspGrpSec  (rspGrpSec),
    .rspPhys    (rspPhys),
    .rspPerm    (rspPerm),
    .rspStatus  (rspStatus)
  );

endmodule

// File: rtl/segHashChk.sv
module segHashChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic [2:0]  reqKind,
  input logic        xlateOnInst,
  input logic        xlateOnData,
  input logic        rspValid,
  input logic [2:0]  rspResult,
  input logic        rspNoExec,
  input logic        rspDirect,
  input logic [23:0] rspHashPri,
  input logic [23:0] rspHashSec,
  input logic [30:0] rspTag,
  input logic [31:0] rspCmpWord,
  input logic [31:0] rspPhys,
  input logic [2:0]  rspPerm,
  input logic [31:0] rspStatus
);

  logic reqReal;
  assign reqReal = (reqKind == 3'd1) ? !xlateOnInst : !xlateOnData;

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R12
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid));

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(rspCmpWord) && $stable(rspResult) && $stable(rspPhys)));

  // R4
  hash_compl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspHashSec == ~rspHashPri));

  // R5
  cmp_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspCmpWord == {1'b1, rspTag}));

  // R10
  real_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReal) |=> (rspResult == 3'd1 && rspPhys == $past(reqAddr) && rspPerm == 3'b111));

  // R7
  noexec_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspResult == 3'd3) |-> (rspStatus == 32'h1000_0000 && rspNoExec && !rspDirect));

  // R11
  lookup_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspResult == 3'd0) |-> (rspPhys == 32'd0 && rspPerm == 3'd0 && !rspDirect));

  // R8
  direct_no_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspDirect) |-> (rspResult != 3'd0 && rspResult != 3'd3));

endmodule

bind segHashUnit segHashChk chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .reqKind    (reqKind),
  .xlateOnInst(xlateOnInst),
  .xlateOnData(xlateOnData),
  .rspValid   (rspValid),
  .rspResult  (rspResult),
  .rspNoExec  (rspNoExec),
  .rspDirect  (rspDirect),
  .rspHashPri (rspHashPri),
  .rspHashSec (rspHashSec),
  .rspTag     (rspTag),
  .rspCmpWord (rspCmpWord),
  .rspPhys    (rspPhys),
  .rspPerm    (rspPerm),
  .rspStatus  (rspStatus)
);

// File: tb/segHashUnit_test.sv
module segHashUnit_test;

  localparam int CLK_PERIOD = 10;
  localparam int MASK_W     = 24;

  logic        clk;
  logic        rstN;
  logic        srWrEn;
  logic [3:0]  srWrIdx;
  logic [31:0] srWrData;
  logic        cfgWrEn;
  logic [31:0] cfgWrBase;
  logic [23:0] cfgWrMask;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic [2:0]  reqKind;
  logic        reqStore;
  logic        reqUser;
  logic        xlateOnInst;
  logic        xlateOnData;
  logic        rspValid;
  logic [2:0]  rspResult;
  logic        rspKey;
  logic        rspNoExec;
  logic        rspDirect;
  logic [23:0] rspVsid;
  logic [23:0] rspHashPri;
  logic [23:0] rspHashSec;
  logic [30:0] rspTag;
  logic [31:0] rspCmpWord;
  logic [31:0] rspGrpPri;
  logic [31:0] rspGrpSec;
  logic [31:0] rspPhys;
  logic [2:0]  rspPerm;
  logic [31:0] rspStatus;

  segHashUnit #(.GROUP_SHIFT(6), .MASK_W(MASK_W)) uut (
    .clk(clk), .rstN(rstN),
    .srWrEn(srWrEn), .srWrIdx(srWrIdx), .srWrData(srWrData),
    .cfgWrEn(cfgWrEn), .cfgWrBase(cfgWrBase), .cfgWrMask(cfgWrMask),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqKind(reqKind),
    .reqStore(reqStore), .reqUser(reqUser),
    .xlateOnInst(xlateOnInst), .xlateOnData(xlateOnData),
    .rspValid(rspValid), .rspResult(rspResult), .rspKey(rspKey),
    .rspNoExec(rspNoExec), .rspDirect(rspDirect), .rspVsid(rspVsid),
    .rspHashPri(rspHashPri), .rspHashSec(rspHashSec), .rspTag(rspTag),
    .rspCmpWord(rspCmpWord), .rspGrpPri(rspGrpPri), .rspGrpSec(rspGrpSec),
    .rspPhys(rspPhys), .rspPerm(rspPerm), .rspStatus(rspStatus)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int          nChecks = 0;
  int          nErr    = 0;
  bit          done    = 0;
  logic [31:0] srM [16];
  logic [31:0] baseM;
  logic [23:0] maskM;
  int          seq = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    srWrEn = 0; srWrIdx = '0; srWrData = '0;
    cfgWrEn = 0; cfgWrBase = '0; cfgWrMask = '0;
    reqValid = 0; reqAddr = '0; reqKind = '0; reqStore = 0; reqUser = 0;
    xlateOnInst = 1; xlateOnData = 1;
  endtask

  task automatic writeSr(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    srWrEn = 1; srWrIdx = idx; srWrData = val;
    @(negedge clk);
    srWrEn = 0;
    srM[idx] = val;
  endtask

  task automatic writeCfg(input logic [31:0] b, input logic [23:0] m);
    @(negedge clk);
    cfgWrEn = 1; cfgWrBase = b; cfgWrMask = m;
    @(negedge clk);
    cfgWrEn = 0;
    baseM = b; maskM = m;
  endtask

  // one request, optionally with same-cycle writes; response checked one cycle later
  task automatic doReq(input logic [31:0] addr, input logic [2:0] kind, input logic st,
                       input logic us, input logic xi, input logic xd,
                       input logic wS, input logic [3:0] wIdx, input logic [31:0] wVal,
                       input logic wC, input logic [31:0] wBase, input logic [23:0] wMask);
    logic [31:0] sr;
    logic        key, ds, nx, realM;
    logic [23:0] vsid, hp, hs;
    logic [15:0] pg;
    logic [30:0] tag;
    logic [31:0] gp, gs, phys, status;
    logic [2:0]  res, perm;
    string       tg;
    @(negedge clk);
    reqValid = 1; reqAddr = addr; reqKind = kind; reqStore = st; reqUser = us;
    xlateOnInst = xi; xlateOnData = xd;
    srWrEn = wS; srWrIdx = wIdx; srWrData = wVal;
    cfgWrEn = wC; cfgWrBase = wBase; cfgWrMask = wMask;
    if (wS) srM[wIdx] = wVal;
    if (wC) begin baseM = wBase; maskM = wMask; end
    @(negedge clk);
    reqValid = 0; srWrEn = 0; cfgWrEn = 0;

    sr    = srM[addr[31:28]];
    key   = (sr[29] & us) | (sr[30] & ~us);
    ds    = sr[31];
    nx    = sr[28];
    vsid  = sr[23:0];
    pg    = addr[27:12];
    hp    = vsid ^ {8'h00, pg};
    hs    = ~hp;
    tag   = {vsid, 1'b0, pg[15:10]};
    gp    = baseM + ({8'h00, hp & maskM} << 6);
    gs    = baseM + ({8'h00, hs & maskM} << 6);
    realM = (kind == 3'd1) ? !xi : !xd;
    phys = 32'd0; perm = 3'd0; status = 32'd0;
    if (realM) begin
      tg = "R10"; res = 3'd1; phys = addr; perm = 3'b111;
    end else if (ds) begin
      if (kind == 3'd0) begin
        tg = "R9";
        if (st ? !key : key) res = 3'd2;
        else begin res = 3'd1; phys = addr; end
      end else if (kind == 3'd4) begin
        tg = "R8"; res = 3'd1; phys = addr;
      end else begin
        tg = "R8"; res = 3'd4;
        if (kind == 3'd1) status = 32'h1000_0000;
      end
    end else if (kind == 3'd1 && nx) begin
      tg = "R7"; res = 3'd3; status = 32'h1000_0000;
    end else begin
      tg = "R11"; res = 3'd0;
    end

    check("R12 rspValid", 32'(rspValid), 32'd1);
    check("R2 key", 32'(rspKey), 32'(key));
    check("R1 R3 direct/noexec", 32'({rspDirect, rspNoExec}), 32'({ds, nx}));
    check("R1 R3 vsid", 32'(rspVsid), 32'(vsid));
    check("R4 hashPri", 32'(rspHashPri), 32'(hp));
    check("R4 hashSec", 32'(rspHashSec), 32'(hs));
    check("R5 tag", 32'(rspTag), 32'(tag));
    check("R5 cmpWord", rspCmpWord, {1'b1, tag});
    check("R6 grpPri", rspGrpPri, gp);
    check("R6 grpSec", rspGrpSec, gs);
    check({tg, " result"}, 32'(rspResult), 32'(res));
    check({tg, " phys"}, rspPhys, phys);
    check({tg, " R11 perm"}, 32'(rspPerm), 32'(perm));
    check({tg, " status"}, rspStatus, status);
  endtask

  function automatic logic [31:0] srPat(input int i, input int p);
    logic [23:0] v;
    v = 24'(i * 24'h13579B) ^ ((p != 0) ? 24'h5A5A5A : 24'hC3C3C3);
    return {4'(i), 4'h0, v};
  endfunction

  task automatic sweep();
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 8; k++) begin
        for (int st = 0; st < 2; st++) begin
          for (int us = 0; us < 2; us++) begin
            for (int xm = 0; xm < 4; xm++) begin
              logic [15:0] pg;
              pg  = 16'(seq * 16'h9E37 + 16'h1234);
              seq = seq + 1;
              doReq({4'(s), pg, 12'(seq * 7)}, 3'(k), 1'(st), 1'(us), xm[0], xm[1],
                    1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 24'd0);
            end
          end
        end
      end
    end
  endtask

  initial begin
    logic [31:0] lastCmp;
    idleInputs();
    for (int i = 0; i < 16; i++) srM[i] = 32'd0;
    baseM = 32'd0; maskM = 24'd0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R14 reset state
    check("R14 rspValid", 32'(rspValid), 32'd0);
    check("R14 rspResult", 32'(rspResult), 32'd0);
    check("R14 rspCmpWord", rspCmpWord, 32'd0);
    check("R14 rspGrpPri", rspGrpPri, 32'd0);
    check("R14 rspPhys", rspPhys, 32'd0);
    check("R14 rspStatus", rspStatus, 32'd0);
    // R14 registers cleared: a lookup before any write sees zero segment and table
    doReq(32'h7ABC_D123, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 24'd0);
    check("R14 vsid after reset", 32'(rspVsid), 32'd0);
    check("R14 grpSec after reset", rspGrpSec, 32'd0);
    // R12 outputs hold with no request
    lastCmp = rspCmpWord;
    @(negedge clk);
    check("R12 no request no valid", 32'(rspValid), 32'd0);
    check("R12 hold cmpWord", rspCmpWord, lastCmp);

    // R1 program all registers, then sweep every segment/kind/direction/privilege/mode
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 16; i++) writeSr(4'(i), srPat(i, p));
      if (p == 0) writeCfg(32'h0010_0000, 24'h0003FF);
      else        writeCfg(32'hFFFF_F000, 24'hFFFFFF);
      sweep();
    end

    // R13 same-cycle segment write to the requested register
    doReq(32'h9123_4567, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1,
          1'b1, 4'd9, 32'h2ABC_DEF0, 1'b0, 32'd0, 24'd0);
    check("R13 bypass vsid", 32'(rspVsid), 32'h00BC_DEF0);
    // R13 write to another register leaves the requested one unchanged
    doReq(32'h4000_1000, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1,
          1'b1, 4'd3, 32'hF000_0001, 1'b0, 32'd0, 24'd0);
    check("R13 neighbour vsid", 32'(rspVsid), 32'(srM[4][23:0]));
    doReq(32'h3FFF_F000, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1,
          1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 24'd0);
    check("R13 later write visible", 32'(rspVsid), 32'h0000_0001);
    // R13 same-cycle configuration write
    doReq(32'h5555_5000, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1,
          1'b0, 4'd0, 32'd0, 1'b1, 32'h0200_0000, 24'h00000F);
    check("R13 cfg bypass grpPri base", rspGrpPri & 32'hFFFF_FC00, 32'h0200_0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule